// File: doc/BRIEF.md
# Counting Semaphore Storage Cell

This block is a single storage cell of an inter-thread communication unit, set up as a counting semaphore rather than a queue. A requester issues one access per cycle: a 4-bit view code, a read or write flag, write data and its own requester index. The view code picks how the access acts on the cell. In the P/V views, a read is a wait (P) operation and a write is a signal (V) operation. Each comes in a blocking form and a try form. The cell also has a bypass view for raw inspection of the count and a control view that exposes a packed tag word. The tag layout is the one shared with the FIFO cells, so a common decoder can read any cell.

A wait returns the count as it was before the operation and then decrements it if it was above zero. When a blocking wait finds the count at zero, the cell raises a stall flag with its response and adds the requester to a blocked mask. A try wait on zero returns at once with no stall. A signal raises the count, saturating at the top. If any requester is blocked, the signal also pulses the whole blocked mask on the wake output and empties the mask. Halting and replaying the stalled requester is left to the surrounding logic, and so is the choice of which cell an address selects.

Top module: `itc_sem_cell`

## Requirements
- R1: After reset the count, the tag flags (T, F, E) and the blocked mask are all zero.
- R2: A read in either P/V view (view 4 blocking, view 5 try) returns the count held before the access, zero-extended. When that count is above zero, it is then lowered by one.
- R3: A blocking wait (view 4 read) on a zero count sets `rsp_stall` with its response, returns 0, leaves the count at 0 and adds bit `req_id` to the blocked mask.
- R4: A try wait (view 5 read) on a zero count returns 0 in one cycle with `rsp_stall` low, and changes neither the count nor the blocked mask.
- R5: A write in either P/V view ignores its data and raises the count by one. The count saturates at 2^COUNT_W-1 (0xFFFF by default).
- R6: A P/V write made while the blocked mask is nonzero drives that mask on `wake` for exactly one cycle and clears it. A P/V write with an empty mask leaves `wake` at zero.
- R7: A bypass read (view 0) returns the count, zero-extended. A bypass write has no effect on the count or the tag.
- R8: A control read (view 1) returns the packed tag: E at bit 0, F at bit 1, T at bit 16, FIFO-type flag at bit 17 (always 0), pointer at bits 27:18 (0) and depth at bits 31:28 (0). A control write loads T, F and E from data bits 16, 1 and 0 and does not touch the count.
- R9: The empty/full views (2 and 3) act on a semaphore cell as a non-FIFO cell: a read returns 0 and a write changes nothing.
- R10: A read in an undefined view (6 to 15) returns all ones. A write in such a view changes nothing.
- R11: Every access gets exactly one response cycle: `rsp_valid` is high in the cycle after `req_valid` and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | VIEW_W (4) | View code selecting the access behaviour |
| req_id | input | ID_W (3) | Index of the requester |
| req_wdata | input | DATA_W (64) | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | DATA_W (64) | Read data of the response |
| rsp_stall | output | 1 | The blocking wait found the count at zero |
| wake | output | NUM_REQ (8) | One-cycle pulse of blocked requesters released by a signal |

## Verification
A wrong count shows up at the next P/V or bypass read, which returns the stored value one cycle after the request. So a decrement or increment that goes astray is visible within two accesses, and a missing saturation shows up on the first read after the top is reached. A corrupted blocked mask stays hidden until the next signal, whose wake pulse then shows extra or missing requesters. The bench therefore follows every blocking or try wait on zero with a signal. Tag corruption appears on the next control-view read.

// File: rtl/itc_sem_pkg.sv
package itc_sem_pkg;

  // View codes seen on req_view; shared with the FIFO cell decoder.
  localparam logic [3:0] VIEW_BYPASS  = 4'd0;
  localparam logic [3:0] VIEW_CTRL    = 4'd1;
  localparam logic [3:0] VIEW_EF_BLK  = 4'd2;
  localparam logic [3:0] VIEW_EF_TRY  = 4'd3;
  localparam logic [3:0] VIEW_PV_BLK  = 4'd4;
  localparam logic [3:0] VIEW_PV_TRY  = 4'd5;

  // Packed tag bit positions, common to every cell type.
  localparam int TAG_E_BIT     = 0;
  localparam int TAG_F_BIT     = 1;
  localparam int TAG_T_BIT     = 16;
  localparam int TAG_FIFO_BIT  = 17;
  localparam int TAG_PTR_LSB   = 18;
  localparam int TAG_DEPTH_LSB = 28;
  localparam int TAG_TOP_BIT   = 31;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_BYP_RD,
    OP_CTL_RD,
    OP_CTL_WR,
    OP_WAIT_BLK,
    OP_WAIT_TRY,
    OP_SIGNAL,
    OP_ZERO_RD,
    OP_ONES_RD
  } sem_op_e;

  typedef struct packed {
    logic t;
    logic f;
    logic e;
  } sem_tag_t;

endpackage

// File: rtl/itc_sem_decode.sv
module itc_sem_decode
  import itc_sem_pkg::*;
#(
  parameter int VIEW_W = 4
) (
  input  logic              valid,
  input  logic              write,
  input  logic [VIEW_W-1:0] view,
  output sem_op_e           op
);

  logic [3:0] view4;
  assign view4 = 4'(view);

  always_comb begin
    op = OP_NONE;
    if (valid) begin
      unique case (view4)
        VIEW_BYPASS: op = write ? OP_NONE   : OP_BYP_RD;
        VIEW_CTRL:   op = write ? OP_CTL_WR : OP_CTL_RD;
        // A semaphore cell is never of FIFO type: empty/full views are inert.
        VIEW_EF_BLK,
        VIEW_EF_TRY: op = write ? OP_NONE   : OP_ZERO_RD;
        VIEW_PV_BLK: op = write ? OP_SIGNAL : OP_WAIT_BLK;
        VIEW_PV_TRY: op = write ? OP_SIGNAL : OP_WAIT_TRY;
        default:     op = write ? OP_NONE   : OP_ONES_RD;
      endcase
    end
  end

endmodule

// File: rtl/itc_sem_counter.sv
module itc_sem_counter #(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               dec,
  output logic [COUNT_W-1:0] count,
  output logic               is_zero
);

  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic [COUNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (inc && count_q != CNT_MAX) begin
      count_q <= count_q + 1'b1;
    end else if (dec && count_q != '0) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign count   = count_q;
  assign is_zero = (count_q == '0);

  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && count_q == CNT_MAX) |=> (count_q == CNT_MAX));

  assert_dec_step_R2: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

  assert_zero_floor_R4: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && count_q == '0) |=> (count_q == '0));

endmodule

// File: rtl/itc_sem_waitlist.sv
module itc_sem_waitlist #(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               add,
  input  logic [ID_W-1:0]    add_id,
  input  logic               flush,
  output logic [NUM_REQ-1:0] mask,
  output logic [NUM_REQ-1:0] wake
);

  logic [NUM_REQ-1:0] mask_q;
  logic [NUM_REQ-1:0] wake_q;
  logic [NUM_REQ-1:0] id_bit;

  // One-hot of the requester, built per bit so any NUM_REQ works.
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_onehot
    assign id_bit[g] = (add_id == ID_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      wake_q <= '0;
    end else begin
      wake_q <= flush ? mask_q : '0;
      if (flush) begin
        mask_q <= '0;
      end else if (add) begin
        mask_q <= mask_q | id_bit;
      end
    end
  end

  assign mask = mask_q;
  assign wake = wake_q;

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (mask_q == '0));

  assert_wake_matches_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (wake_q == $past(mask_q)));

  assert_wake_only_on_flush_R6: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (wake_q == '0));

  assert_add_records_R3: assert property (@(posedge clk) disable iff (rst)
    (add && !flush) |=> mask_q[$past(add_id)]);

endmodule

// File: rtl/itc_sem_cell.sv
module itc_sem_cell
  import itc_sem_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int COUNT_W = 16,
  parameter int VIEW_W  = 4,
  parameter int NUM_REQ = 8,
  parameter int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [VIEW_W-1:0]  req_view,
  input  logic [ID_W-1:0]    req_id,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_stall,
  output logic [NUM_REQ-1:0] wake
);

  localparam int PAD_W = DATA_W - COUNT_W;

  sem_op_e            op;
  logic [COUNT_W-1:0] count;
  logic               cnt_zero;
  logic               cnt_inc;
  logic               cnt_dec;
  logic               wl_add;
  logic               wl_flush;
  logic [NUM_REQ-1:0] wl_mask;
  sem_tag_t           tag_q;
  logic [DATA_W-1:0]  ctl_word;
  logic [DATA_W-1:0]  rdata_d;
  logic               rsp_valid_q;
  logic               rsp_stall_q;
  logic [DATA_W-1:0]  rsp_rdata_q;

  itc_sem_decode #(.VIEW_W(VIEW_W)) u_decode (
    .valid (req_valid),
    .write (req_write),
    .view  (req_view),
    .op    (op)
  );

  assign cnt_inc  = (op == OP_SIGNAL);
  assign cnt_dec  = (op == OP_WAIT_BLK) || (op == OP_WAIT_TRY);
  assign wl_add   = (op == OP_WAIT_BLK) && cnt_zero;
  assign wl_flush = (op == OP_SIGNAL);

  itc_sem_counter #(.COUNT_W(COUNT_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .inc     (cnt_inc),
    .dec     (cnt_dec),
    .count   (count),
    .is_zero (cnt_zero)
  );

  itc_sem_waitlist #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_waitlist (
    .clk    (clk),
    .rst    (rst),
    .add    (wl_add),
    .add_id (req_id),
    .flush  (wl_flush),
    .mask   (wl_mask),
    .wake   (wake)
  );

  // Tag flags; pointer, depth and FIFO-type fields stay zero for this cell.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (op == OP_CTL_WR) begin
      tag_q.t <= req_wdata[TAG_T_BIT];
      tag_q.f <= req_wdata[TAG_F_BIT];
      tag_q.e <= req_wdata[TAG_E_BIT];
    end
  end

  always_comb begin
    ctl_word            = '0;
    ctl_word[TAG_E_BIT] = tag_q.e;
    ctl_word[TAG_F_BIT] = tag_q.f;
    ctl_word[TAG_T_BIT] = tag_q.t;
  end

  always_comb begin
    unique case (op)
      OP_BYP_RD,
      OP_WAIT_BLK,
      OP_WAIT_TRY: rdata_d = {{PAD_W{1'b0}}, count};
      OP_CTL_RD:   rdata_d = ctl_word;
      OP_ONES_RD:  rdata_d = '1;
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_stall_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_stall_q <= wl_add;
      rsp_rdata_q <= req_valid ? rdata_d : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_stall = rsp_stall_q;
  assign rsp_rdata = rsp_rdata_q;

  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_stall_has_resp_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_stall |-> (rsp_valid && rsp_rdata == '0));

  assert_try_keeps_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WAIT_TRY) |=> $stable(wl_mask));

  assert_ctl_word_shape_R8: assert property (@(posedge clk) disable iff (rst)
    $past(op == OP_CTL_RD) |-> (rsp_rdata[TAG_TOP_BIT:TAG_FIFO_BIT] == '0));

endmodule

// File: tb/itc_sem_cell_bench.sv
module itc_sem_cell_bench;

  localparam int DATA_W  = 64;
  localparam int COUNT_W = 16;
  localparam int VIEW_W  = 4;
  localparam int NUM_REQ = 8;
  localparam int ID_W    = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_write = 1'b0;
  logic [VIEW_W-1:0]  req_view  = '0;
  logic [ID_W-1:0]    req_id    = '0;
  logic [DATA_W-1:0]  req_wdata = '0;
  logic               rsp_valid;
  logic [DATA_W-1:0]  rsp_rdata;
  logic               rsp_stall;
  logic [NUM_REQ-1:0] wake;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [DATA_W-1:0]  got_data;
  logic               got_stall;
  logic               got_valid;
  logic [NUM_REQ-1:0] got_wake;

  always #4 clk = ~clk;

  itc_sem_cell #(
    .DATA_W(DATA_W), .COUNT_W(COUNT_W), .VIEW_W(VIEW_W),
    .NUM_REQ(NUM_REQ), .ID_W(ID_W)
  ) u_itc_sem_cell (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_view(req_view),
    .req_id(req_id), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_stall(rsp_stall), .wake(wake)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One access: drive at a falling edge, capture response at the next one.
  task automatic access(input bit wr, input int view, input int id,
                        input logic [63:0] wdata);
    req_valid = 1'b1;
    req_write = wr;
    req_view  = VIEW_W'(view);
    req_id    = ID_W'(id);
    req_wdata = wdata;
    @(negedge clk);
    got_data  = rsp_rdata;
    got_stall = rsp_stall;
    got_valid = rsp_valid;
    got_wake  = wake;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_wdata = '0;
  endtask

  task automatic bypass_count(input logic [63:0] exp, input string req);
    access(1'b0, 0, 0, '0);
    check(got_data == exp, req, got_data, exp);
  endtask

  task automatic t_reset;
    bypass_count(64'd0, "R1 count zero after reset");
    access(1'b0, 1, 0, '0);
    check(got_data == 64'd0, "R1 tag zero after reset", got_data, 64'd0);
    access(1'b1, 5, 0, 64'hDEAD);
    check(got_wake == '0, "R1 empty mask after reset", 64'(got_wake), 64'd0);
    access(1'b0, 5, 0, '0);
    check(got_data == 64'd1, "R2 try wait returns one", got_data, 64'd1);
    bypass_count(64'd0, "R2 count decremented to zero");
  endtask

  task automatic t_wait_sequence;
    access(1'b1, 4, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    access(1'b1, 5, 0, 64'h5);
    access(1'b1, 4, 0, 64'h0);
    bypass_count(64'd3, "R5 three signals give three");
    for (int k = 3; k >= 1; k--) begin
      access(1'b0, 4, 1, '0);
      check(got_data == 64'(k) && !got_stall, "R2 blocking wait pre-decrement value",
            got_data, 64'(k));
    end
    bypass_count(64'd0, "R2 count drained");
  endtask

  task automatic t_block_and_wake;
    access(1'b0, 4, 2, '0);
    check(got_stall == 1'b1, "R3 stall on zero", 64'(got_stall), 64'd1);
    check(got_data == 64'd0, "R3 stall returns zero", got_data, 64'd0);
    access(1'b0, 4, 5, '0);
    check(got_stall == 1'b1, "R3 second stall", 64'(got_stall), 64'd1);
    bypass_count(64'd0, "R3 count stays zero");
    access(1'b1, 4, 0, '0);
    check(got_wake == 8'b0010_0100, "R6 wake pulse carries mask", 64'(got_wake), 64'h24);
    access(1'b1, 5, 0, '0);
    check(got_wake == '0, "R6 mask cleared after wake", 64'(got_wake), 64'd0);
    bypass_count(64'd2, "R6 both signals counted");
  endtask

  task automatic t_try_on_zero;
    access(1'b0, 5, 0, '0);
    access(1'b0, 5, 0, '0);
    access(1'b0, 5, 3, '0);
    check(!got_stall && got_data == 64'd0, "R4 try on zero no stall",
          {got_stall, got_data[62:0]}, 64'd0);
    check(got_valid == 1'b1, "R4 try answered in one cycle", 64'(got_valid), 64'd1);
    bypass_count(64'd0, "R4 count unchanged");
    access(1'b1, 5, 0, '0);
    check(got_wake == '0, "R4 mask untouched by try", 64'(got_wake), 64'd0);
    access(1'b0, 5, 0, '0);
  endtask

  task automatic t_bypass_write;
    access(1'b1, 4, 0, '0);
    access(1'b1, 0, 0, 64'h1234);
    bypass_count(64'd1, "R7 bypass write ignored");
    access(1'b0, 1, 0, '0);
    check(got_data == 64'd0, "R7 bypass write leaves tag", got_data, 64'd0);
  endtask

  task automatic t_control;
    access(1'b1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    access(1'b0, 1, 0, '0);
    check(got_data == 64'h0001_0003, "R8 tag packing", got_data, 64'h0001_0003);
    bypass_count(64'd1, "R8 control write keeps count");
    access(1'b1, 1, 0, 64'h0001_0000);
    access(1'b0, 1, 0, '0);
    check(got_data == 64'h0001_0000, "R8 T only", got_data, 64'h0001_0000);
    access(1'b1, 1, 0, 64'h0);
  endtask

  task automatic t_ef_views;
    access(1'b0, 2, 0, '0);
    check(got_data == 64'd0, "R9 blocking ef read zero", got_data, 64'd0);
    access(1'b1, 3, 0, 64'h77);
    access(1'b1, 2, 0, 64'h77);
    access(1'b0, 3, 0, '0);
    check(got_data == 64'd0, "R9 try ef read zero", got_data, 64'd0);
    bypass_count(64'd1, "R9 ef writes change nothing");
  endtask

  task automatic t_bad_views;
    access(1'b0, 6, 0, '0);
    check(got_data == '1, "R10 undefined view reads ones", got_data, '1);
    access(1'b1, 15, 0, 64'h1_0003);
    access(1'b0, 15, 0, '0);
    check(got_data == '1, "R10 view 15 reads ones", got_data, '1);
    bypass_count(64'd1, "R10 undefined write no effect");
    access(1'b0, 1, 0, '0);
    check(got_data == 64'd0, "R10 tag unchanged", got_data, 64'd0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 idle no response", 64'(rsp_valid), 64'd0);
    access(1'b0, 0, 0, '0);
    check(got_valid == 1'b1, "R11 response after request", 64'(got_valid), 64'd1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 single response cycle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_saturation;
    for (int k = 0; k < 65536; k++) begin
      access(1'b1, (k % 2 == 0) ? 4 : 5, 0, 64'(k));
    end
    bypass_count(64'hFFFF, "R5 count saturates");
    access(1'b0, 4, 0, '0);
    check(got_data == 64'hFFFF, "R5 wait at top returns max", got_data, 64'hFFFF);
    bypass_count(64'hFFFE, "R5 decrement below max");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wait_sequence();
    t_block_and_wake();
    t_try_on_zero();
    t_bypass_write();
    t_control();
    t_ef_views();
    t_bad_views();
    t_latency();
    t_saturation();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule